// File: doc/BRIEF.md
# Dual-Rail Logic and Shift Array

This block is the logic-and-shift half of a self-timed ALU datapath. It is built from identical one-bit slices. In logic mode, each slice applies one of the sixteen two-input Boolean functions to its own pair of operand bits. In shift mode, each slice instead forwards a B bit from a neighbouring slice, so that B moves one place left or right. Serial fill inputs supply the bit that enters at the top or bottom end of the word.

Each slice reports its result as a dual-rail pair, qualified by the start input and the enable mode bit. While start is low, or the mode bit deselects the unit, both rails sit at zero. This is the spacer state. Once an operation is valid, exactly one rail of each pair is high. A completion detector ANDs the resolved state of all pairs into a done flag, which a self-timed controller uses to advance.

The pairs, the result word and done are registered once on the clock. Every input set appears at the outputs one cycle after it is sampled.

Top module: `dr_logic_shift_top`

## Requirements
- R1: While rst_n is low at a rising clock edge, the next outputs are all zero: word_o, rail_t_o, rail_f_o and done_o.
- R2: When mode_en_i is 0, the next cycle has rail_t_o and rail_f_o both all-zero and done_o at 0.
- R3: When go_i is 0, the next cycle has both rail vectors all-zero and done_o at 0 (spacer state).
- R4: With mode_en_i=1, go_i=1 and mode_shift_i=0, result bit j is fn_i[{a_i[j], b_i[j]}]. That is, fn_i[3] is selected for A=1,B=1, fn_i[2] for A=1,B=0, fn_i[1] for A=0,B=1 and fn_i[0] for A=0,B=0.
- R5: With mode_shift_i=1 and dir_right_i=1, result bit j is b_i[j+1]. The top bit N-1 takes fill_msb_i.
- R6: With mode_shift_i=1 and dir_right_i=0, result bit j is b_i[j-1]. Bit 0 takes fill_lsb_i.
- R7: For a valid operation, rail_t_o holds the result and rail_f_o holds its complement. A bit never has both rails high.
- R8: done_o is 1 exactly when every pair has one rail high. It follows go_i with one cycle of latency and falls the cycle after go_i falls.
- R9: word_o always equals rail_t_o.
- R10: Outputs reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_i | input | N | Operand A |
| b_i | input | N | Operand B, also the shift source |
| fn_i | input | 4 | Boolean function code, indexed by {A,B} |
| mode_shift_i | input | 1 | 1 = shift, 0 = bitwise logic |
| mode_en_i | input | 1 | 1 = unit selected for logic/shift |
| dir_right_i | input | 1 | Shift direction, 1 = right, 0 = left |
| go_i | input | 1 | Start; 0 forces the spacer state |
| fill_msb_i | input | 1 | Bit entering the top on a right shift (tie low for zero fill) |
| fill_lsb_i | input | 1 | Bit entering the bottom on a left shift (tie low for zero fill) |
| word_o | output | N | Result word (true rails) |
| rail_t_o | output | N | True rail per bit |
| rail_f_o | output | N | False rail per bit |
| done_o | output | 1 | All bits resolved |

## Verification
All sixteen function codes are applied to an operand pair that contains every (A,B) combination across its bits, and then to random operands. A wrong minterm-to-code mapping therefore shows up as a specific bit mismatch. Shifts run in both directions on patterns whose two end bits differ, with each fill input set to both 0 and 1. This separates direction swaps, off-by-one neighbours and swapped fill inputs. Toggling go_i and mode_en_i against a held operation checks that the spacer state and done track the start signal with one cycle of latency.

// File: rtl/dr_alu_pkg.sv
// Package: shared constants and types for the dual-rail logic/shift array.
// Assumes: function codes are always four bits wide (one per minterm).
package dr_alu_pkg;
    localparam int FN_W = 4;

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } shift_dir_e;

    typedef struct packed {
        logic t;
        logic f;
    } rail_pair_t;
endpackage

// File: rtl/dr_bit_slice.sv
// Module: one bit of the logic/shift array.
// Selects either a Boolean function of (a,b) or a neighbour B bit, then
// encodes the result as a dual-rail pair gated by go and the enable mode.
// Assumes: the neighbour inputs are already resolved to fill bits at the ends.
module dr_bit_slice
    import dr_alu_pkg::*;
(
    input  logic            a,
    input  logic            b,
    input  logic            b_hi,
    input  logic            b_lo,
    input  logic [FN_W-1:0] fn,
    input  logic            m_shift,
    input  logic            m_en,
    input  logic            dir_right,
    input  logic            go,
    output rail_pair_t      pair
);
    logic logic_x;
    logic shift_x;
    logic sel_x;
    logic qual;

    // Four-to-one mux: the minterm {a,b} picks its bit of the function code.
    always_comb logic_x = fn[{a, b}];

    // Shift source: the more-significant neighbour for right, the less-significant for left.
    always_comb shift_x = (shift_dir_e'(dir_right) == DIR_RIGHT) ? b_hi : b_lo;

    // Mode mux between bitwise logic and shift.
    always_comb sel_x = m_shift ? shift_x : logic_x;

    // Dual-rail encoding; both rails stay low unless started and enabled.
    always_comb begin
        qual   = go & m_en;
        pair.t = qual & sel_x;
        pair.f = qual & ~sel_x;
    end
endmodule

// File: rtl/dr_completion.sv
// Module: completion detector for N dual-rail pairs.
// Raises done when go is high and every pair has one rail asserted.
// Assumes: the pairs are never 1/1 (guaranteed by the slices).
module dr_completion #(
    parameter int N = 8
) (
    input  logic [N-1:0] t,
    input  logic [N-1:0] f,
    input  logic         go,
    output logic         done
);
    logic [N-1:0] resolved;

    // Per-bit resolved flag, then an AND across the word.
    always_comb begin
        resolved = t | f;
        done     = go & (&resolved);
    end
endmodule

// File: rtl/dr_logic_shift_top.sv
// Module: N-bit dual-rail logic and shift array.
// Instantiates N identical slices, wires each slice to its neighbours and to
// the fill bits at the ends, registers the rails once, and derives done.
// Assumes: synchronous active-low reset; one cycle of latency, input to output.
module dr_logic_shift_top
    import dr_alu_pkg::*;
#(
    parameter int N = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    a_i,
    input  logic [N-1:0]    b_i,
    input  logic [FN_W-1:0] fn_i,
    input  logic            mode_shift_i,
    input  logic            mode_en_i,
    input  logic            dir_right_i,
    input  logic            go_i,
    input  logic            fill_msb_i,
    input  logic            fill_lsb_i,
    output logic [N-1:0]    word_o,
    output logic [N-1:0]    rail_t_o,
    output logic [N-1:0]    rail_f_o,
    output logic            done_o
);
    localparam int TOP = N - 1;

    rail_pair_t   pair_w [N];
    logic [N-1:0] t_d;
    logic [N-1:0] f_d;
    logic [N-1:0] t_q;
    logic [N-1:0] f_q;
    logic         go_q;
    logic         done_w;

    for (genvar j = 0; j < N; j++) begin : g_slice
        logic nb_hi;
        logic nb_lo;

        if (j == TOP) begin : g_top
            assign nb_hi = fill_msb_i;
        end else begin : g_mid_hi
            assign nb_hi = b_i[j+1];
        end

        if (j == 0) begin : g_bot
            assign nb_lo = fill_lsb_i;
        end else begin : g_mid_lo
            assign nb_lo = b_i[j-1];
        end

        dr_bit_slice u_slice (
            .a         (a_i[j]),
            .b         (b_i[j]),
            .b_hi      (nb_hi),
            .b_lo      (nb_lo),
            .fn        (fn_i),
            .m_shift   (mode_shift_i),
            .m_en      (mode_en_i),
            .dir_right (dir_right_i),
            .go        (go_i),
            .pair      (pair_w[j])
        );

        assign t_d[j] = pair_w[j].t;
        assign f_d[j] = pair_w[j].f;
    end

    // Output register for the rails and the start qualifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q  <= '0;
            f_q  <= '0;
            go_q <= 1'b0;
        end else begin
            t_q  <= t_d;
            f_q  <= f_d;
            go_q <= go_i;
        end
    end

    dr_completion #(.N(N)) u_done (
        .t    (t_q),
        .f    (f_q),
        .go   (go_q),
        .done (done_w)
    );

    // Drive the ports from the registered state.
    always_comb begin
        rail_t_o = t_q;
        rail_f_o = f_q;
        word_o   = t_q;
        done_o   = done_w;
    end
endmodule

// File: rtl/dr_logic_shift_chk.sv
// Module: assertion checker bound to dr_logic_shift_top.
// Relates sampled inputs to the registered rails and done one cycle later.
module dr_logic_shift_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         go_i,
    input logic         mode_en_i,
    input logic [N-1:0] rail_t_o,
    input logic [N-1:0] rail_f_o,
    input logic         done_o
);
    // R7: never both rails of one bit.
    assert_rails_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_t_o & rail_f_o) == '0);

    // R3: idle start gives the spacer state next cycle.
    assert_spacer_on_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !go_i |=> (rail_t_o == '0 && rail_f_o == '0 && !done_o));

    // R2: a deselected unit drives no rail.
    assert_mode_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en_i |=> (rail_t_o == '0 && rail_f_o == '0 && !done_o));

    // R8: a valid operation resolves every bit and raises done.
    assert_valid_resolves_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && mode_en_i) |=> (done_o && ((rail_t_o | rail_f_o) == '1)));

    // R8: done is only seen after go was high.
    assert_done_needs_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(go_i));
endmodule

bind dr_logic_shift_top dr_logic_shift_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (go_i),
    .mode_en_i (mode_en_i),
    .rail_t_o  (rail_t_o),
    .rail_f_o  (rail_f_o),
    .done_o    (done_o)
);

// File: tb/dr_logic_shift_top_tb_top.sv
`timescale 1ns/1ps
module dr_logic_shift_top_tb_top;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] a_i = '0, b_i = '0;
    logic [3:0]   fn_i = '0;
    logic         mode_shift_i = 0, mode_en_i = 0, dir_right_i = 0, go_i = 0;
    logic         fill_msb_i = 0, fill_lsb_i = 0;
    logic [N-1:0] word_o, rail_t_o, rail_f_o;
    logic         done_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dr_logic_shift_top #(.N(N)) dut_i (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural reference: result bit for the held inputs.
    function automatic logic [N-1:0] ref_x();
        logic [N-1:0] r;
        for (int j = 0; j < N; j++) begin
            if (!mode_shift_i) begin
                if (a_i[j] && b_i[j])       r[j] = fn_i[3];
                else if (a_i[j])            r[j] = fn_i[2];
                else if (b_i[j])            r[j] = fn_i[1];
                else                        r[j] = fn_i[0];
            end else if (dir_right_i) begin
                r[j] = (j == N-1) ? fill_msb_i : b_i[j+1];
            end else begin
                r[j] = (j == 0) ? fill_lsb_i : b_i[j-1];
            end
        end
        return r;
    endfunction

    // Wait one clock, then compare the outputs against the model at the falling edge.
    task automatic step();
        logic [N-1:0] et, ef;
        logic         ed;
        string        req;
        @(posedge clk);
        @(negedge clk);
        if (!rst_n) begin
            et = '0; ef = '0; ed = 0; req = "R1";
        end else if (!mode_en_i) begin
            et = '0; ef = '0; ed = 0; req = "R2";
        end else if (!go_i) begin
            et = '0; ef = '0; ed = 0; req = "R3";
        end else begin
            et = ref_x(); ef = ~et; ed = 1;
            req = !mode_shift_i ? "R4" : (dir_right_i ? "R5" : "R6");
        end
        chk({req, "/R10 true rails"}, 32'(rail_t_o), 32'(et));
        chk("R7 false rails", 32'(rail_f_o), 32'(ef));
        chk("R8 done", 32'(done_o), 32'(ed));
        chk("R9 word", 32'(word_o), 32'(rail_t_o));
        chk("R7 exclusive", 32'(rail_t_o & rail_f_o), 32'd0);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        go_i = 1; mode_en_i = 1; a_i = '1; b_i = '1; fn_i = 4'hF;
        step(); step();                          // R1 under reset
        rst_n = 1;
        // R4: every code against all minterms, then random operands
        a_i = 8'b1100_1010; b_i = 8'b1010_1100; mode_shift_i = 0;
        for (int c = 0; c < 16; c++) begin fn_i = 4'(c); step(); end
        for (int k = 0; k < 32; k++) begin
            a_i = 8'($urandom); b_i = 8'($urandom); fn_i = 4'($urandom); step();
        end
        // R5/R6: both directions, both fill values
        mode_shift_i = 1;
        for (int d = 0; d < 2; d++)
            for (int fl = 0; fl < 4; fl++) begin
                dir_right_i = d[0]; fill_msb_i = fl[0]; fill_lsb_i = fl[1];
                b_i = 8'b0110_1001; step();
                b_i = 8'b1000_0001; step();
                b_i = 8'($urandom); step();
            end
        // R3/R8: done falls after go falls, rises after go rises
        dir_right_i = 1; b_i = 8'hA5;
        go_i = 0; step(); step();
        go_i = 1; step();
        go_i = 0; step();
        // R2: deselected unit stays quiet
        go_i = 1; mode_en_i = 0; step();
        mode_shift_i = 0; fn_i = 4'hF; step();
        mode_en_i = 1; step();
        // R1: reset mid-operation clears outputs
        rst_n = 0; step();
        rst_n = 1; step();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule